// File: doc/BRIEF.md
# Event-Matched Multi-Output PWM Timer

This block is a single up-counting timer that drives a bank of outputs through a matrix of match-triggered events. Each event compares one match register against the counter. Each output has its own set mask and clear mask over the events. When an event in the set mask fires, the output goes high. When an event in the clear mask fires, the output goes low. A limit mask names the events that return the counter to zero, and that return sets the period.

Every match register has a reload twin. The twin's value is copied into the match register at each limit wrap, so a new period or duty value starts on a cycle boundary. A set and a clear can land on the same output in the same tick. A 2-bit action per output settles that case. With these pieces, software can build ordinary PWM channels of either polarity that share one period. It can also build odd waveforms from any mix of events.

Registers are write-only over a simple strobe bus. The address splits into a 4-bit group (bits 7:4) and a 4-bit index (bits 3:0).

Top module: `pwm_evt_timer`

## Requirements
- R1: After reset, `pwm_o` and `count_o` are zero and the timer is halted. The counter does not move until address 0x01 is written with bit 2 clear.
- R2: Address 0x01 holds halt in bit 2 and a prescaler PRE in bits 12:5. While not halted, the counter advances once every PRE+1 clocks. While halted, neither the counter nor any output changes.
- R3: Event e is set up by two registers. Address 0x30+e holds the match-register select in bits 3:0 and the enable in bit 12. Address 0x40+e holds the state mask in bit 0. The event fires on a count tick when both enable bits are set and the selected match register equals the counter. With either bit clear, it never fires.
- R4: Address 0x02 holds the limit event mask. On a tick where a limit event fires, the counter goes to 0 instead of incrementing. A period event with match value P-1 gives a period of P ticks.
- R5: Addresses 0x50+o and 0x60+o hold the set mask and clear mask of output o. On a tick where an event in the set mask fires, the output becomes 1. On a tick where an event in the clear mask fires, it becomes 0. The change appears together with the counter update of that tick.
- R6: Address 0x03 holds 2 bits per output at bit position 2*o. They decide the result when set and clear fire on the same tick: 0 keeps the old value, 1 sets, 2 clears, 3 toggles.
- R7: Addresses 0x10+e (match) and 0x20+e (reload) hold the compare values. At every limit wrap, each reload value is copied into its match register. Writing only the reload of the period event therefore changes the period starting with the next cycle.
- R8: Normal polarity means set on the period event and clear on a duty event at match D. It keeps the output high for counter values 0..D. D=0 gives one tick high. D=P-1 stays high through conflict action 1. Inverted polarity means set on the duty event and clear on the period event. It is high for counter values D+1..P-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address: group in 7:4, index in 3:0 |
| bus_wdata | input | 32 | Register write data |
| pwm_o | output | 16 | Registered outputs |
| count_o | output | 32 | Current counter value |

## Verification
A corrupt match, reload or select register shows up at the first period wrap. It appears as a wrong period on `count_o` or as an edge landing on the wrong count on `pwm_o`, within one period of the fault. A wrong conflict action or mask bit shows at the next count where the events coincide. Toggle needs two periods to be told apart from set. A prescaler or halt fault shows within PRE+1 clocks as a count that moves too early, too late, or while halted.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  typedef enum logic [1:0] {
    RES_HOLD = 2'd0,
    RES_SET  = 2'd1,
    RES_CLR  = 2'd2,
    RES_TGL  = 2'd3
  } res_t;

  localparam int GRP_W = 4;
  localparam int IDX_W = 4;

  localparam logic [GRP_W-1:0] GRP_GLOBAL = 4'h0;
  localparam logic [GRP_W-1:0] GRP_MATCH  = 4'h1;
  localparam logic [GRP_W-1:0] GRP_RELOAD = 4'h2;
  localparam logic [GRP_W-1:0] GRP_EVCTL  = 4'h3;
  localparam logic [GRP_W-1:0] GRP_EVMSK  = 4'h4;
  localparam logic [GRP_W-1:0] GRP_OSET   = 4'h5;
  localparam logic [GRP_W-1:0] GRP_OCLR   = 4'h6;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 4'h1;
  localparam logic [IDX_W-1:0] IDX_LIMIT = 4'h2;
  localparam logic [IDX_W-1:0] IDX_RES   = 4'h3;

  localparam int HALT_BIT   = 2;
  localparam int PRE_LSB    = 5;
  localparam int EVC_EN_BIT = 12;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;

  assign tick = !halt && (div_q >= pre);

  always_ff @(posedge clk) begin
    if (rst || halt || tick) div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_evt_cmp.sv
module pwm_evt_cmp #(
  parameter int NUM_EV = 16,
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 4
) (
  input  logic                           tick,
  input  logic                           en,
  input  logic [SEL_W-1:0]               sel,
  input  logic [NUM_EV-1:0][CNT_W-1:0]   match_arr,
  input  logic [CNT_W-1:0]               cnt,
  output logic                           fire
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_EV; i++)
      if (sel == SEL_W'(i) && match_arr[i] == cnt) hit = 1'b1;
  end

  assign fire = tick && en && hit;
endmodule

// File: rtl/pwm_out_cell.sv
module pwm_out_cell
  import pwm_evt_pkg::*;
#(
  parameter int NUM_EV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NUM_EV-1:0] fire,
  input  logic [NUM_EV-1:0] set_m,
  input  logic [NUM_EV-1:0] clr_m,
  input  res_t              res,
  output logic              out_q
);
  logic set_hit, clr_hit;

  assign set_hit = |(fire & set_m);
  assign clr_hit = |(fire & clr_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
    end else if (tick) begin
      if (set_hit && clr_hit) begin
        case (res)
          RES_HOLD: out_q <= out_q;
          RES_SET:  out_q <= 1'b1;
          RES_CLR:  out_q <= 1'b0;
          RES_TGL:  out_q <= ~out_q;
          default:  out_q <= out_q;
        endcase
      end else if (set_hit) begin
        out_q <= 1'b1;
      end else if (clr_hit) begin
        out_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_evt_timer.sv
module pwm_evt_timer
  import pwm_evt_pkg::*;
#(
  parameter int NUM_OUT = 16,
  parameter int NUM_EV  = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_we,
  input  logic [GRP_W+IDX_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [NUM_OUT-1:0]       pwm_o,
  output logic [CNT_W-1:0]         count_o
);
  localparam int SEL_W  = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;
  localparam int ADDR_W = GRP_W + IDX_W;

  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx;
  assign grp = bus_addr[ADDR_W-1:IDX_W];
  assign idx = bus_addr[IDX_W-1:0];

  logic                            halt_q;
  logic [PRE_W-1:0]                pre_q;
  logic [NUM_EV-1:0]               limit_q;
  logic [2*NUM_OUT-1:0]            res_q;
  logic [NUM_EV-1:0][CNT_W-1:0]    match_q;
  logic [NUM_EV-1:0][CNT_W-1:0]    reload_q;
  logic [NUM_EV-1:0][SEL_W-1:0]    evsel_q;
  logic [NUM_EV-1:0]               evon_q;
  logic [NUM_EV-1:0]               evmask_q;
  logic [NUM_OUT-1:0][NUM_EV-1:0]  set_q;
  logic [NUM_OUT-1:0][NUM_EV-1:0]  clr_q;

  logic              tick;
  logic              wrap;
  logic [NUM_EV-1:0] fire;
  logic [CNT_W-1:0]  cnt_q;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= 1'b1;
      pre_q   <= '0;
      limit_q <= '0;
      res_q   <= '0;
    end else if (bus_we && grp == GRP_GLOBAL) begin
      case (idx)
        IDX_CTRL: begin
          halt_q <= bus_wdata[HALT_BIT];
          pre_q  <= bus_wdata[PRE_LSB +: PRE_W];
        end
        IDX_LIMIT: limit_q <= bus_wdata[NUM_EV-1:0];
        IDX_RES:   res_q   <= bus_wdata[2*NUM_OUT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q  <= '0;
      reload_q <= '0;
      evsel_q  <= '0;
      evon_q   <= '0;
      evmask_q <= '0;
    end else begin
      for (int e = 0; e < NUM_EV; e++) begin
        if (bus_we && grp == GRP_MATCH && idx == IDX_W'(e))
          match_q[e] <= bus_wdata[CNT_W-1:0];
        else if (wrap)
          match_q[e] <= reload_q[e];
        if (bus_we && grp == GRP_RELOAD && idx == IDX_W'(e))
          reload_q[e] <= bus_wdata[CNT_W-1:0];
        if (bus_we && grp == GRP_EVCTL && idx == IDX_W'(e)) begin
          evsel_q[e] <= bus_wdata[SEL_W-1:0];
          evon_q[e]  <= bus_wdata[EVC_EN_BIT];
        end
        if (bus_we && grp == GRP_EVMSK && idx == IDX_W'(e))
          evmask_q[e] <= bus_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q <= '0;
      clr_q <= '0;
    end else begin
      for (int o = 0; o < NUM_OUT; o++) begin
        if (bus_we && grp == GRP_OSET && idx == IDX_W'(o))
          set_q[o] <= bus_wdata[NUM_EV-1:0];
        if (bus_we && grp == GRP_OCLR && idx == IDX_W'(o))
          clr_q[o] <= bus_wdata[NUM_EV-1:0];
      end
    end
  end

  pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .halt (halt_q),
    .pre  (pre_q),
    .tick (tick)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_evt
    pwm_evt_cmp #(.NUM_EV(NUM_EV), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_cmp (
      .tick      (tick),
      .en        (evon_q[g] & evmask_q[g]),
      .sel       (evsel_q[g]),
      .match_arr (match_q),
      .cnt       (cnt_q),
      .fire      (fire[g])
    );
  end

  assign wrap = |(fire & limit_q);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    pwm_out_cell #(.NUM_EV(NUM_EV)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .fire  (fire),
      .set_m (set_q[g]),
      .clr_m (clr_q[g]),
      .res   (res_t'(res_q[2*g +: 2])),
      .out_q (pwm_o[g])
    );
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pwm_evt_timer_chk.sv
module pwm_evt_timer_chk #(
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               wrap,
  input logic               halt_q,
  input logic [NUM_OUT-1:0] pwm_o,
  input logic [CNT_W-1:0]   count_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pwm_o == '0 && count_o == '0));

  a_r2_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> ($stable(count_o) && $stable(pwm_o)));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_o));

  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count_o == '0));

  a_r5_out_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pwm_o));
endmodule

bind pwm_evt_timer pwm_evt_timer_chk #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wrap    (wrap),
  .halt_q  (halt_q),
  .pwm_o   (pwm_o),
  .count_o (count_o)
);

// File: tb/pwm_evt_timer_tb.sv
module pwm_evt_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] pwm_o;
  logic [31:0] count_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    string       req;
    logic [31:0] cnt;
    bit          chk_cnt;
    logic [15:0] out;
    logic [15:0] mask;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  pwm_evt_timer u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pwm_o(pwm_o), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic push(input string req, input logic [31:0] c, input bit cc,
                      input logic [15:0] o, input logic [15:0] m);
    item_t it;
    it.req = req; it.cnt = c; it.chk_cnt = cc; it.out = o; it.mask = m;
    sbq.push_back(it);
  endtask

  // monitor: compare one expected item per clock, sampled after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        if (it.chk_cnt) chk({it.req, " count"}, count_o, it.cnt);
        chk({it.req, " out"}, {16'h0, pwm_o & it.mask}, {16'h0, it.out & it.mask});
      end
    end
  end

  task automatic wr_now(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic set_ev(input int e, input logic [31:0] m, input logic [31:0] ctl, input logic [31:0] msk);
    wr(8'h10 | 8'(e), m);
    wr(8'h20 | 8'(e), m);
    wr(8'h30 | 8'(e), ctl);
    wr(8'h40 | 8'(e), msk);
  endtask

  task automatic set_out(input int o, input logic [15:0] s, input logic [15:0] c);
    wr(8'h50 | 8'(o), {16'h0, s});
    wr(8'h60 | 8'(o), {16'h0, c});
  endtask

  task automatic wait_cnt(input logic [31:0] v);
    do @(negedge clk); while (count_o != v);
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset pwm", {16'h0, pwm_o}, 32'h0);
    chk("R1 reset count", count_o, 32'h0);
    repeat (5) @(negedge clk);
    #1;
    chk("R1 halted after reset", count_o, 32'h0);

    // events: period 10 (match 9), duty 3, inverted duty 6, ev3 selects match0,
    // duty-0 event, ev5 not enabled, ev6 state mask clear
    set_ev(0, 32'd9, 32'h1000, 32'h1);
    set_ev(1, 32'd3, 32'h1001, 32'h1);
    set_ev(2, 32'd6, 32'h1002, 32'h1);
    set_ev(3, 32'd0, 32'h1000, 32'h1);
    set_ev(4, 32'd0, 32'h1004, 32'h1);
    set_ev(5, 32'd2, 32'h0005, 32'h1);
    set_ev(6, 32'd2, 32'h1006, 32'h0);
    wr(8'h02, 32'h1);
    wr(8'h03, 32'h1399);
    set_out(0, 16'h0001, 16'h0002);
    set_out(1, 16'h0004, 16'h0001);
    set_out(2, 16'h0001, 16'h0008);
    set_out(3, 16'h0001, 16'h0008);
    set_out(4, 16'h0001, 16'h0008);
    set_out(5, 16'h0008, 16'h0003);
    set_out(6, 16'h0001, 16'h0010);
    set_out(7, 16'h0020, 16'h0001);
    set_out(8, 16'h0040, 16'h0001);
    #1;
    chk("R1 still halted after setup", count_o, 32'h0);

    wr(8'h01, 32'h0);
    wait_cnt(32'd9);
    wait_cnt(32'd0);
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 10; c++) begin
        logic [15:0] e;
        e = '0;
        e[0] = (c <= 3);          // R8 normal polarity
        e[1] = (c >= 7);          // R8 inverted polarity
        e[2] = 1'b1;              // R6 conflict set, duty = period-1
        e[3] = 1'b0;              // R6 conflict clear
        e[4] = (k == 0);          // R6 conflict toggle
        e[5] = 1'b0;              // R6 conflict hold
        e[6] = (c == 0);          // R8 duty 0
        e[7] = 1'b0;              // R3 event not enabled
        e[8] = 1'b0;              // R3 state mask clear
        push("R4 R5 R6 R8 main", 32'(c), 1'b1, e, 16'hFFFF);
      end
    end
    drain();

    // R7: reload only, mid-cycle
    wait_cnt(32'd2);
    wr_now(8'h20, 32'd5);
    for (int c = 3; c < 10; c++) push("R7 old period", 32'(c), 1'b1, 16'(c <= 3), 16'h1);
    for (int k = 0; k < 2; k++)
      for (int c = 0; c < 6; c++) push("R7 new period", 32'(c), 1'b1, 16'(c <= 3), 16'h1);
    drain();

    // R2: prescaler 2 -> one count every 3 clocks
    wr(8'h01, 32'h40);
    wait_cnt(32'd5);
    wait_cnt(32'd0);
    for (int c = 0; c < 7; c++)
      for (int r = 0; r < 3; r++)
        push("R2 prescaler", 32'(c % 6), 1'b1, 16'((c % 6) <= 3), 16'h1);
    drain();

    // R2: halt freezes counter and outputs
    wr(8'h01, 32'h44);
    begin
      logic [31:0] c0;
      logic [15:0] o0;
      c0 = count_o;
      o0 = pwm_o;
      for (int i = 0; i < 15; i++) push("R2 halt", c0, 1'b1, o0, 16'hFFFF);
    end
    drain();

    finish_run();
  end
endmodule